// File: doc/BRIEF.md
# Adapter Option-Select and Memory Window Decoder

This block holds the identity and option-select registers of a network adapter and decodes the adapter's relocatable 16 KB host memory window. Software reaches the option registers through an 8-byte I/O block. The block has two fixed identity bytes, an enable byte and a window-base byte. The enable byte switches the card's memory window and the boot ROM on and off independently. The window base is programmed as host address bits 19:14, so the window can be placed on any 16 KB boundary. The block also holds an interrupt-selection byte.

On the memory side, each host access is compared with the programmed base. On a hit, the offset inside the window is decoded. Offsets below 0x3FC0 select the dual-ported RAM. Above that, in ascending order, come a 32-byte station-address PROM, 16 reserved bytes, the 16-bit data register, the control/status byte, the command byte, and a reserved tail. The PROM is an internal constant table. Its valid bytes sit only on even offsets, and the station address starts with the fixed vendor prefix 00:00:A5.

The data paths of the selected targets are out of scope. The exception is the PROM byte, which is returned on a local read bus. Reserved and odd PROM bytes read as 0xFF on that bus.

Top module: `adapter_cfg_decoder`

## Requirements
- R1: I/O offset 0 reads 0xFD and offset 1 reads 0x6A. Writes to these offsets change nothing that any port shows.
- R2: I/O offset 2 is read/write. Bit 0 drives card_en_o, and bit 1 set disables the boot ROM, so boot_rom_en_o is the inverse of bit 1. A read returns {6'b0, bit1, bit0}.
- R3: The low 6 bits of I/O offset 3 hold the window base, compared with host address bits 19:14. A read returns {2'b0, base}.
- R4: I/O offset 4 is an 8-bit read/write interrupt selection that appears on irq_sel_o.
- R5: I/O offsets 5, 6 and 7 read 0xFF, and writes to them are ignored.
- R6: A memory access hits only when mem_req_i is 1, card enable is 1, and mem_addr_i[19:14] equals the base. With no hit, no select is asserted and local_rdata_o is 0xFF. At most one select is ever asserted.
- R7: Window offsets 0x0000 to 0x3FBF assert ram_sel_o, with ram_addr_o equal to the offset.
- R8: Offsets 0x3FC0 to 0x3FDF assert prom_sel_o. For PROM index k = offset - 0x3FC0, an odd k returns 0xFF. An even k below 12 returns station byte k/2 of 00, 00, A5 followed by the 24-bit device suffix, most significant byte first. An even k of 12 or more returns 0x00.
- R9: Offsets 0x3FF0 and 0x3FF1 assert dreg_sel_o, and dreg_hi_o equals offset bit 0. Offset 0x3FF2 asserts ctl_sel_o, and offset 0x3FF3 asserts cmd_sel_o.
- R10: Offsets 0x3FE0 to 0x3FEF and 0x3FF4 to 0x3FFF assert rsv_sel_o and read 0xFF on local_rdata_o.
- R11: Reset clears offsets 2, 3 and 4 to zero. This leaves the card disabled and the boot ROM enabled.
- R12: A register write takes effect on the clock edge that ends its cycle. A memory access in the same cycle decodes against the old enable and base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_sel_i | input | 1 | I/O block access strobe |
| io_we_i | input | 1 | I/O write when 1 |
| io_addr_i | input | 3 | I/O offset |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data for io_addr_i |
| card_en_o | output | 1 | Card and memory window enabled |
| boot_rom_en_o | output | 1 | Boot ROM enabled |
| irq_sel_o | output | 8 | Interrupt selection byte |
| mem_req_i | input | 1 | Host memory access valid |
| mem_addr_i | input | 20 | Host memory byte address |
| ram_sel_o | output | 1 | Dual-ported RAM selected |
| ram_addr_o | output | 14 | RAM byte offset (0 when not selected) |
| prom_sel_o | output | 1 | Station-address PROM selected |
| dreg_sel_o | output | 1 | 16-bit data register selected |
| dreg_hi_o | output | 1 | Upper byte of data register addressed |
| ctl_sel_o | output | 1 | Control/status byte selected |
| cmd_sel_o | output | 1 | Command byte selected |
| rsv_sel_o | output | 1 | Reserved window byte addressed |
| local_rdata_o | output | 8 | PROM byte, or 0xFF |

## Verification
An option-register write and a memory access can fall in the same cycle. A write that turns the card on, or that moves the base, may arrive while the host touches an address that the new value would hit or the old value would miss. The bench issues such pairs on purpose, both in directed steps and in a long pseudo-random mix. Its reference model applies the write only after comparing that cycle's decode, so the decode in the write cycle is judged against the old enable and base, and the decode in the following cycle against the new ones.

// File: rtl/adapter_cfg_pkg.sv
package adapter_cfg_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned IO_AW    = 3;
  localparam int unsigned HOST_AW  = 20;
  localparam int unsigned WIN_AW   = 14;
  localparam int unsigned BASE_W   = HOST_AW - WIN_AW;

  typedef enum logic [2:0] {
    RG_NONE, RG_RAM, RG_PROM, RG_RSV, RG_DREG, RG_CTL, RG_CMD
  } win_region_e;

  typedef struct packed {
    logic              card_en;
    logic              rom_off;
    logic [BASE_W-1:0] base;
    logic [BYTE_W-1:0] irq;
  } opt_regs_t;
endpackage

// File: rtl/adapter_opt_regs.sv
module adapter_opt_regs
  import adapter_cfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_LO = 8'hFD,
  parameter logic [BYTE_W-1:0] ID_HI = 8'h6A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_sel_i,
  input  logic              io_we_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [BYTE_W-1:0] io_wdata_i,
  output logic [BYTE_W-1:0] io_rdata_o,
  output opt_regs_t         regs_o
);
  localparam logic [IO_AW-1:0] OFS_ID_LO = 3'd0;
  localparam logic [IO_AW-1:0] OFS_ID_HI = 3'd1;
  localparam logic [IO_AW-1:0] OFS_EN    = 3'd2;
  localparam logic [IO_AW-1:0] OFS_BASE  = 3'd3;
  localparam logic [IO_AW-1:0] OFS_IRQ   = 3'd4;

  opt_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (io_sel_i && io_we_i) begin
      unique case (io_addr_i)
        OFS_EN: begin
          regs_q.card_en <= io_wdata_i[0];
          regs_q.rom_off <= io_wdata_i[1];
        end
        OFS_BASE: regs_q.base <= io_wdata_i[BASE_W-1:0];
        OFS_IRQ:  regs_q.irq  <= io_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (io_addr_i)
      OFS_ID_LO: io_rdata_o = ID_LO;
      OFS_ID_HI: io_rdata_o = ID_HI;
      OFS_EN:    io_rdata_o = {{(BYTE_W-2){1'b0}}, regs_q.rom_off, regs_q.card_en};
      OFS_BASE:  io_rdata_o = {{(BYTE_W-BASE_W){1'b0}}, regs_q.base};
      OFS_IRQ:   io_rdata_o = regs_q.irq;
      default:   io_rdata_o = '1;
    endcase
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/adapter_win_region.sv
module adapter_win_region
  import adapter_cfg_pkg::*;
#(
  parameter int unsigned RAM_BYTES  = 'h3FC0,
  parameter int unsigned PROM_BYTES = 32,
  parameter int unsigned RSV_BYTES  = 16
) (
  input  logic              req_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic              card_en_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [WIN_AW-1:0] ofs_o,
  output win_region_e       region_o
);
  localparam logic [WIN_AW-1:0] PROM_LO = WIN_AW'(RAM_BYTES);
  localparam logic [WIN_AW-1:0] RSV_LO  = WIN_AW'(RAM_BYTES + PROM_BYTES);
  localparam logic [WIN_AW-1:0] DREG_LO = WIN_AW'(RAM_BYTES + PROM_BYTES + RSV_BYTES);
  localparam logic [WIN_AW-1:0] DREG_HI = DREG_LO + WIN_AW'(1);
  localparam logic [WIN_AW-1:0] CTL_AD  = DREG_LO + WIN_AW'(2);
  localparam logic [WIN_AW-1:0] CMD_AD  = DREG_LO + WIN_AW'(3);

  logic hit;

  assign hit   = req_i && card_en_i && (addr_i[HOST_AW-1:WIN_AW] == base_i);
  assign ofs_o = addr_i[WIN_AW-1:0];

  always_comb begin
    if (!hit)                                         region_o = RG_NONE;
    else if (ofs_o < PROM_LO)                         region_o = RG_RAM;
    else if (ofs_o < RSV_LO)                          region_o = RG_PROM;
    else if (ofs_o < DREG_LO)                         region_o = RG_RSV;
    else if (ofs_o == DREG_LO || ofs_o == DREG_HI)    region_o = RG_DREG;
    else if (ofs_o == CTL_AD)                         region_o = RG_CTL;
    else if (ofs_o == CMD_AD)                         region_o = RG_CMD;
    else                                              region_o = RG_RSV;
  end
endmodule

// File: rtl/adapter_station_prom.sv
module adapter_station_prom
  import adapter_cfg_pkg::*;
#(
  parameter int unsigned       PROM_BYTES = 32,
  parameter logic [23:0]       VENDOR_OUI = 24'h0000A5,
  parameter logic [23:0]       DEV_SUFFIX = 24'h1A2B3C,
  parameter logic [BYTE_W-1:0] PROM_FILL  = 8'h00,
  localparam int unsigned      PROM_AW    = $clog2(PROM_BYTES)
) (
  input  logic [PROM_AW-1:0] idx_i,
  output logic [BYTE_W-1:0]  data_o
);
  localparam int unsigned SLOTS    = PROM_BYTES / 2;
  localparam int unsigned MAC_LEN  = 6;
  localparam logic [8*MAC_LEN-1:0] STATION = {VENDOR_OUI, DEV_SUFFIX};

  logic [BYTE_W-1:0] slot_tbl [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < MAC_LEN) begin : g_mac
      assign slot_tbl[g] = STATION[8*(MAC_LEN-g)-1 -: 8];
    end else begin : g_fill
      assign slot_tbl[g] = PROM_FILL;
    end
  end

  // odd bytes are not driven by the 8-bit part
  assign data_o = idx_i[0] ? '1 : slot_tbl[idx_i[PROM_AW-1:1]];
endmodule

// File: rtl/adapter_cfg_decoder.sv
module adapter_cfg_decoder
  import adapter_cfg_pkg::*;
#(
  parameter logic [7:0]  ID_LO      = 8'hFD,
  parameter logic [7:0]  ID_HI      = 8'h6A,
  parameter logic [23:0] VENDOR_OUI = 24'h0000A5,
  parameter logic [23:0] DEV_SUFFIX = 24'h1A2B3C,
  parameter logic [7:0]  PROM_FILL  = 8'h00,
  parameter int unsigned RAM_BYTES  = 'h3FC0,
  parameter int unsigned PROM_BYTES = 32,
  parameter int unsigned RSV_BYTES  = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         io_sel_i,
  input  logic         io_we_i,
  input  logic [2:0]   io_addr_i,
  input  logic [7:0]   io_wdata_i,
  output logic [7:0]   io_rdata_o,
  output logic         card_en_o,
  output logic         boot_rom_en_o,
  output logic [7:0]   irq_sel_o,
  input  logic         mem_req_i,
  input  logic [19:0]  mem_addr_i,
  output logic         ram_sel_o,
  output logic [13:0]  ram_addr_o,
  output logic         prom_sel_o,
  output logic         dreg_sel_o,
  output logic         dreg_hi_o,
  output logic         ctl_sel_o,
  output logic         cmd_sel_o,
  output logic         rsv_sel_o,
  output logic [7:0]   local_rdata_o
);
  localparam int unsigned PROM_AW = $clog2(PROM_BYTES);

  opt_regs_t         regs;
  win_region_e       region;
  logic [WIN_AW-1:0] ofs;
  logic [BYTE_W-1:0] prom_byte;

  adapter_opt_regs #(.ID_LO(ID_LO), .ID_HI(ID_HI)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .io_sel_i   (io_sel_i),
    .io_we_i    (io_we_i),
    .io_addr_i  (io_addr_i),
    .io_wdata_i (io_wdata_i),
    .io_rdata_o (io_rdata_o),
    .regs_o     (regs)
  );

  adapter_win_region #(
    .RAM_BYTES(RAM_BYTES), .PROM_BYTES(PROM_BYTES), .RSV_BYTES(RSV_BYTES)
  ) u_region (
    .req_i     (mem_req_i),
    .addr_i    (mem_addr_i),
    .card_en_i (regs.card_en),
    .base_i    (regs.base),
    .ofs_o     (ofs),
    .region_o  (region)
  );

  adapter_station_prom #(
    .PROM_BYTES(PROM_BYTES), .VENDOR_OUI(VENDOR_OUI),
    .DEV_SUFFIX(DEV_SUFFIX), .PROM_FILL(PROM_FILL)
  ) u_prom (
    .idx_i  (ofs[PROM_AW-1:0]),
    .data_o (prom_byte)
  );

  assign card_en_o     = regs.card_en;
  assign boot_rom_en_o = ~regs.rom_off;
  assign irq_sel_o     = regs.irq;

  assign ram_sel_o  = (region == RG_RAM);
  assign prom_sel_o = (region == RG_PROM);
  assign dreg_sel_o = (region == RG_DREG);
  assign ctl_sel_o  = (region == RG_CTL);
  assign cmd_sel_o  = (region == RG_CMD);
  assign rsv_sel_o  = (region == RG_RSV);

  assign ram_addr_o    = ram_sel_o ? ofs : '0;
  assign dreg_hi_o     = dreg_sel_o & ofs[0];
  assign local_rdata_o = prom_sel_o ? prom_byte : '1;
endmodule

// File: rtl/adapter_cfg_decoder_chk.sv
module adapter_cfg_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_sel_i,
  input logic        io_we_i,
  input logic [2:0]  io_addr_i,
  input logic [7:0]  io_wdata_i,
  input logic [7:0]  io_rdata_o,
  input logic        card_en_o,
  input logic [7:0]  irq_sel_o,
  input logic        mem_req_i,
  input logic [19:0] mem_addr_i,
  input logic        ram_sel_o,
  input logic [13:0] ram_addr_o,
  input logic        prom_sel_o,
  input logic        dreg_sel_o,
  input logic        ctl_sel_o,
  input logic        cmd_sel_o,
  input logic        rsv_sel_o,
  input logic [7:0]  local_rdata_o
);
  logic [5:0] sels;
  assign sels = {ram_sel_o, prom_sel_o, dreg_sel_o, ctl_sel_o, cmd_sel_o, rsv_sel_o};

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sels)); // R6
  AST_SEL_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sels) |-> (card_en_o && mem_req_i)); // R6
  AST_RAM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o |-> (ram_addr_o < 14'h3FC0 && ram_addr_o == mem_addr_i[13:0])); // R7
  AST_ID_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i == 3'd0) |-> (io_rdata_o == 8'hFD)); // R1
  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i && io_we_i && io_addr_i == 3'd2) |=> (card_en_o == $past(io_wdata_i[0]))); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_sel_i && io_we_i && io_addr_i == 3'd4) |=> $stable(irq_sel_o)); // R4
  AST_PROM_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prom_sel_o && mem_addr_i[0]) |-> (local_rdata_o == 8'hFF)); // R8
  AST_RSV_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_sel_o |-> (local_rdata_o == 8'hFF)); // R10
endmodule

bind adapter_cfg_decoder adapter_cfg_decoder_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .io_sel_i      (io_sel_i),
  .io_we_i       (io_we_i),
  .io_addr_i     (io_addr_i),
  .io_wdata_i    (io_wdata_i),
  .io_rdata_o    (io_rdata_o),
  .card_en_o     (card_en_o),
  .irq_sel_o     (irq_sel_o),
  .mem_req_i     (mem_req_i),
  .mem_addr_i    (mem_addr_i),
  .ram_sel_o     (ram_sel_o),
  .ram_addr_o    (ram_addr_o),
  .prom_sel_o    (prom_sel_o),
  .dreg_sel_o    (dreg_sel_o),
  .ctl_sel_o     (ctl_sel_o),
  .cmd_sel_o     (cmd_sel_o),
  .rsv_sel_o     (rsv_sel_o),
  .local_rdata_o (local_rdata_o)
);

// File: tb/adapter_cfg_decoder_test.sv
`timescale 1ns/100ps
module adapter_cfg_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_sel_i = 1'b0, io_we_i = 1'b0, mem_req_i = 1'b0;
  logic [2:0]  io_addr_i = '0;
  logic [7:0]  io_wdata_i = '0;
  logic [19:0] mem_addr_i = '0;
  logic [7:0]  io_rdata_o, irq_sel_o, local_rdata_o;
  logic        card_en_o, boot_rom_en_o, ram_sel_o, prom_sel_o, dreg_sel_o;
  logic        dreg_hi_o, ctl_sel_o, cmd_sel_o, rsv_sel_o;
  logic [13:0] ram_addr_o;

  always #2 clk = ~clk;

  adapter_cfg_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .io_sel_i(io_sel_i), .io_we_i(io_we_i),
    .io_addr_i(io_addr_i), .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o),
    .card_en_o(card_en_o), .boot_rom_en_o(boot_rom_en_o), .irq_sel_o(irq_sel_o),
    .mem_req_i(mem_req_i), .mem_addr_i(mem_addr_i), .ram_sel_o(ram_sel_o),
    .ram_addr_o(ram_addr_o), .prom_sel_o(prom_sel_o), .dreg_sel_o(dreg_sel_o),
    .dreg_hi_o(dreg_hi_o), .ctl_sel_o(ctl_sel_o), .cmd_sel_o(cmd_sel_o),
    .rsv_sel_o(rsv_sel_o), .local_rdata_o(local_rdata_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int m_en = 0, m_roff = 0, m_base = 0, m_irq = 0;
  int station[6] = '{8'h00, 8'h00, 8'hA5, 8'h1A, 8'h2B, 8'h3C};
  string cur_tag = "";
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv, string what);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic int exp_io(int a);
    case (a)
      0: return 8'hFD;
      1: return 8'h6A;
      2: return (m_roff << 1) | m_en;
      3: return m_base;
      4: return m_irq;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string io_tag(int a);
    case (a)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  // region codes: 0 none, 1 ram, 2 prom, 3 rsv, 4 dreg, 5 ctl, 6 cmd
  task automatic compare_all();
    int a, ofs, rg, k, ebyte;
    logic [5:0] esel;
    string tg;
    a = int'(io_addr_i);
    chk({cur_tag, io_tag(a)}, {24'd0, io_rdata_o}, exp_io(a), "io_rdata");
    chk({cur_tag, "R2"}, {31'd0, card_en_o}, m_en, "card_en");
    chk({cur_tag, "R2"}, {31'd0, boot_rom_en_o}, (m_roff == 0), "boot_rom_en");
    chk({cur_tag, "R4"}, {24'd0, irq_sel_o}, m_irq, "irq_sel");
    ofs = int'(mem_addr_i) & 'h3FFF;
    if (!(mem_req_i && m_en == 1 && (int'(mem_addr_i) >> 14) == m_base)) rg = 0;
    else if (ofs < 'h3FC0) rg = 1;
    else if (ofs < 'h3FE0) rg = 2;
    else if (ofs < 'h3FF0) rg = 3;
    else if (ofs < 'h3FF2) rg = 4;
    else if (ofs == 'h3FF2) rg = 5;
    else if (ofs == 'h3FF3) rg = 6;
    else rg = 3;
    case (rg)
      0: begin tg = "R6"; esel = 6'b000000; end
      1: begin tg = "R7"; esel = 6'b100000; end
      2: begin tg = "R8"; esel = 6'b010000; end
      3: begin tg = "R10"; esel = 6'b000001; end
      4: begin tg = "R9"; esel = 6'b001000; end
      5: begin tg = "R9"; esel = 6'b000100; end
      default: begin tg = "R9"; esel = 6'b000010; end
    endcase
    tg = {cur_tag, tg};
    chk(tg, {26'd0, ram_sel_o, prom_sel_o, dreg_sel_o, ctl_sel_o, cmd_sel_o, rsv_sel_o},
        esel, $sformatf("selects @%05h", mem_addr_i));
    if (rg == 1) chk(tg, {18'd0, ram_addr_o}, ofs, "ram_addr");
    if (rg == 4) chk(tg, {31'd0, dreg_hi_o}, ofs & 1, "dreg_hi");
    ebyte = 8'hFF;
    if (rg == 2) begin
      k = ofs - 'h3FC0;
      if (k % 2 == 1) ebyte = 8'hFF;
      else if (k / 2 < 6) ebyte = station[k / 2];
      else ebyte = 8'h00;
    end
    chk(tg, {24'd0, local_rdata_o}, ebyte, $sformatf("local_rdata @%05h", mem_addr_i));
  endtask

  // drive at negedge, check before the edge, update model at the edge
  task automatic step(bit sel, bit we, int ioa, int wd, bit req, int addr);
    io_sel_i = sel; io_we_i = we; io_addr_i = 3'(ioa); io_wdata_i = 8'(wd);
    mem_req_i = req; mem_addr_i = 20'(addr);
    #1;
    compare_all();
    @(posedge clk);
    if (sel && we) begin
      case (ioa)
        2: begin m_en = wd & 1; m_roff = (wd >> 1) & 1; end
        3: m_base = wd & 'h3F;
        4: m_irq = wd & 'hFF;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic io_wr(int a, int d); step(1, 1, a, d, 0, 0); endtask
  task automatic mem_rd(int addr); step(0, 0, 0, 0, 1, addr); endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: reset state, observed with the reset held
    repeat (2) @(negedge clk);
    cur_tag = "R11/";
    for (int a = 0; a < 8; a++) begin
      io_addr_i = 3'(a); mem_req_i = 1'b1; mem_addr_i = 20'h00010;
      #1; compare_all();
      @(negedge clk);
    end
    rst_ni = 1'b1;
    cur_tag = "";
    @(negedge clk);
    for (int a = 0; a < 8; a++) step(0, 0, a, 0, 0, 0);
    // R1, R5: writes to read-only and unused offsets
    io_wr(0, 8'h00); io_wr(1, 8'h12);
    for (int a = 5; a < 8; a++) io_wr(a, 8'hAA);
    for (int a = 0; a < 8; a++) step(0, 0, a, 0, 0, 0);
    // R2, R3, R4
    io_wr(3, 8'hF3); step(0, 0, 3, 0, 0, 0);
    io_wr(4, 8'h5A); step(0, 0, 4, 0, 0, 0);
    io_wr(2, 8'h02); step(0, 0, 2, 0, 0, 0);
    // R6: card disabled, window address misses
    mem_rd('hCC000); mem_rd('hCFFC0);
    // R12: enable written in the same cycle as an access
    cur_tag = "R12/";
    step(1, 1, 2, 8'h01, 1, 'hCC010);
    step(0, 0, 2, 0, 1, 'hCC010);
    cur_tag = "";
    // R8: whole PROM
    for (int k = 0; k < 32; k++) mem_rd('hCFFC0 + k);
    // R10, R9: reserved and register bytes
    for (int k = 'h3FE0; k < 'h4000; k++) mem_rd('hCC000 + k);
    // R7: RAM edges
    mem_rd('hCC000); mem_rd('hCDEAD); mem_rd('hCFFBF);
    // R6: wrong base and no request
    mem_rd('hC8000); mem_rd('hD0000); step(0, 0, 0, 0, 0, 'hCC000);
    // R12: base moved in the same cycle as accesses at both bases
    cur_tag = "R12/";
    step(1, 1, 3, 8'h3F, 1, 'hFFFC0);
    step(0, 0, 3, 0, 1, 'hFFFC0);
    step(1, 1, 3, 8'h33, 1, 'hFFFC2);
    step(0, 0, 3, 0, 1, 'hFFFC2);
    cur_tag = "";
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r, q;
      int b, o, ioa;
      r = rnd(); q = rnd();
      b = r[14] ? m_base : int'(r[20:15]);
      o = q[3] ? (32'h3FC0 | int'(q[9:4])) : int'(q[27:14]);
      ioa = int'(r[4:2]);
      if (ioa == 3 && r[21]) ioa = 2;
      step(r[0], r[1], ioa, int'(r[12:5]), r[13], (b << 14) | o);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule